// File: doc/BRIEF.md
# Scatter-Gather Page List Address Generator

This block produces the physical memory addresses for a DMA data stream whose buffer is scattered across 4 KB pages. Software leaves a table of page frame words in system memory. The block receives the table's base address, a byte offset into the first page, a byte length, a direction and a list-mode enable. It reads table entries through a memory-read request port and forms every data address from the current page frame and a 12-bit in-page offset. The data mover consumes the addresses through a valid/ready beat port.

A beat carries at most `BEAT_BYTES` bytes and never runs past a beat-aligned boundary, the end of the page, or the end of the transfer. When the in-page offset wraps at a 4 KB boundary, the block requests the next table entry. The table pointer steps one 32-bit word at each read, and the new page always starts at offset zero. With list mode off, the base address is used as a flat starting byte address, and the frame simply increments at each page crossing. When the remaining count reaches zero, a done flag rises and stays high until the next start.

The controller has four states:
- **IDLE**: waits for `start`. It leaves for DONE when the length is zero, for FETCH in list mode, and for XFER otherwise.
- **FETCH**: holds `lst_req` until `lst_rvalid`, then moves to XFER.
- **XFER**: holds `beat_valid`. On an accepted beat it moves to DONE if that was the last beat. It moves to FETCH if the beat closed a page in list mode. Otherwise it stays in XFER.
- **DONE**: asserts `done` and leaves on `start` along the same arcs as IDLE.

Top module: `sg_addr_gen`

## Requirements
- R1: After reset, `lst_req`, `beat_valid` and `done` are all low.
- R2: In list mode the first table read addresses `cfg_list_base`, and each later read addresses the previous read address plus 4. There is exactly one read per 4 KB page that the transfer touches.
- R3: Bits 31:12 of a returned table word become the page frame, and bits 11:0 of that word are ignored. The first beat address is {frame of entry 0, `cfg_offset`}.
- R4: `beat_valid` is never high while a table read is outstanding (`lst_req` high).
- R5: A beat's byte count (`beat_bytes`) is the smaller of (`BEAT_BYTES` minus the address modulo `BEAT_BYTES`) and the remaining byte count. A beat never crosses a 4 KB boundary.
- R6: After a page crossing in list mode, the address continues at offset zero of the frame given by the next table entry.
- R7: The remaining count drops by `beat_bytes` on each accepted beat. `done` rises in the cycle after the beat that consumes the last byte, and no table read or beat follows while `done` is high.
- R8: With `cfg_sg_en` low, no table read is made. Beat addresses run linearly from `cfg_list_base`, including across page boundaries.
- R9: `beat_dir` equals the value of `cfg_dir` captured at the accepted start.
- R10: A start with `cfg_len` equal to 0 raises `done` one cycle later, with no table read and no beat.
- R11: `start` is ignored while a transfer is in progress (FETCH or XFER).
- R12: An unanswered table read holds `lst_req` and `lst_addr` steady. A beat that is not accepted holds `beat_valid`, `beat_addr` and `beat_bytes` steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted in IDLE or DONE) |
| cfg_sg_en | input | 1 | 1: page-list mode, 0: flat linear mode |
| cfg_dir | input | 1 | Direction tag passed to `beat_dir` |
| cfg_list_base | input | ADDR_W | Table base (list mode) or start byte address (flat mode) |
| cfg_offset | input | PAGE_BITS | Starting offset within the first page (list mode) |
| cfg_len | input | LEN_W | Transfer length in bytes |
| lst_req | output | 1 | Table read request, held until answered |
| lst_addr | output | ADDR_W | Address of the table word requested |
| lst_rvalid | input | 1 | Table word returned this cycle |
| lst_rdata | input | ADDR_W | Returned table word |
| beat_valid | output | 1 | Data beat address valid |
| beat_addr | output | ADDR_W | Byte address of the beat |
| beat_bytes | output | BB_W | Bytes in the beat |
| beat_dir | output | 1 | Captured direction |
| beat_ready | input | 1 | Data mover accepts the beat |
| done | output | 1 | Transfer finished, held until the next start |

## Verification
Random transfers mix list and flat mode, random start offsets and lengths, random table-read latency and random beat stalls. The expected address and byte count of every accepted beat come from a page-walk model in the bench. Unaligned offsets separate correct beat-size clipping from a plain fixed step. Directed cases cover:
- an offset at 4095, where a single byte precedes the first page crossing;
- a transfer ending exactly on a page boundary, which shows whether a spurious extra table read follows the last beat;
- a full single page starting at offset zero;
- zero length;
- a start pulse issued in the middle of a transfer.

Flat-mode runs across a page boundary tell an incrementing frame apart from a table fetch.

// File: rtl/sg_pkg.sv
package sg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_XFER  = 2'd2,
        ST_DONE  = 2'd3
    } sg_state_e;
endpackage

// File: rtl/sg_beat_calc.sv
module sg_beat_calc #(
    parameter int BEAT_BYTES = 4,
    parameter int LEN_W      = 16,
    localparam int AL_W      = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 1,
    localparam int BB_W      = $clog2(BEAT_BYTES) + 1
) (
    input  logic [AL_W-1:0]  addr_low,
    input  logic [LEN_W-1:0] remaining,
    output logic [BB_W-1:0]  bytes
);
    logic [BB_W-1:0] room;

    generate
        if (BEAT_BYTES > 1) begin : g_wide
            always_comb room = BB_W'(BEAT_BYTES) - BB_W'(addr_low);
        end else begin : g_byte
            logic unused_low;
            always_comb unused_low = addr_low[0];
            always_comb room = BB_W'(1);
        end
    endgenerate

    always_comb begin
        if (remaining < LEN_W'(room)) bytes = BB_W'(remaining);
        else                          bytes = room;
    end
endmodule

// File: rtl/sg_fsm.sv
module sg_fsm
    import sg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic len_zero,
    input  logic list_mode_req,
    input  logic list_mode_q,
    input  logic lst_rvalid,
    input  logic beat_ready,
    input  logic last_beat,
    input  logic page_end,
    output logic load,
    output logic take_entry,
    output logic take_beat,
    output logic lst_req,
    output logic beat_valid,
    output logic done
);
    sg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    if (len_zero)           state_d = ST_DONE;
                    else if (list_mode_req) state_d = ST_FETCH;
                    else                    state_d = ST_XFER;
                end
            end
            ST_FETCH: begin
                if (lst_rvalid) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (beat_ready) begin
                    if (last_beat)                     state_d = ST_DONE;
                    else if (page_end && list_mode_q)  state_d = ST_FETCH;
                    else                               state_d = ST_XFER;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        lst_req    = 1'b0;
        beat_valid = 1'b0;
        done       = 1'b0;
        load       = 1'b0;
        take_entry = 1'b0;
        take_beat  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = start;
            end
            ST_FETCH: begin
                lst_req    = 1'b1;
                take_entry = lst_rvalid;
            end
            ST_XFER: begin
                beat_valid = 1'b1;
                take_beat  = beat_ready;
            end
            ST_DONE: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sg_cursor.sv
module sg_cursor #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int PAGE_BITS  = 12,
    parameter int BEAT_BYTES = 4,
    localparam int FRAME_W   = ADDR_W - PAGE_BITS,
    localparam int BB_W      = $clog2(BEAT_BYTES) + 1,
    localparam int ENTRY_B   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 take_entry,
    input  logic                 take_beat,
    input  logic                 cfg_sg_en,
    input  logic                 cfg_dir,
    input  logic [ADDR_W-1:0]    cfg_list_base,
    input  logic [PAGE_BITS-1:0] cfg_offset,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic [ADDR_W-1:0]    entry_word,
    input  logic [BB_W-1:0]      bytes,
    output logic [ADDR_W-1:0]    list_ptr,
    output logic [FRAME_W-1:0]   frame,
    output logic [PAGE_BITS-1:0] offset,
    output logic [LEN_W-1:0]     remaining,
    output logic                 list_mode,
    output logic                 dir,
    output logic                 page_end,
    output logic                 last_beat
);
    logic [PAGE_BITS:0] off_sum;

    always_comb begin
        off_sum   = {1'b0, offset} + (PAGE_BITS+1)'(bytes);
        page_end  = off_sum[PAGE_BITS];
        last_beat = (remaining == LEN_W'(bytes));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            list_ptr  <= '0;
            frame     <= '0;
            offset    <= '0;
            remaining <= '0;
            list_mode <= 1'b0;
            dir       <= 1'b0;
        end else if (load) begin
            list_ptr  <= cfg_list_base;
            remaining <= cfg_len;
            list_mode <= cfg_sg_en;
            dir       <= cfg_dir;
            if (cfg_sg_en) begin
                frame  <= '0;
                offset <= cfg_offset;
            end else begin
                frame  <= cfg_list_base[ADDR_W-1:PAGE_BITS];
                offset <= cfg_list_base[PAGE_BITS-1:0];
            end
        end else if (take_entry) begin
            frame    <= entry_word[ADDR_W-1:PAGE_BITS];
            list_ptr <= list_ptr + ADDR_W'(ENTRY_B);
        end else if (take_beat) begin
            remaining <= remaining - LEN_W'(bytes);
            offset    <= off_sum[PAGE_BITS-1:0];
            if (page_end && !list_mode) frame <= frame + FRAME_W'(1);
        end
    end
endmodule

// File: rtl/sg_addr_gen.sv
module sg_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int PAGE_BITS  = 12,
    parameter int BEAT_BYTES = 4,
    localparam int FRAME_W   = ADDR_W - PAGE_BITS,
    localparam int BB_W      = $clog2(BEAT_BYTES) + 1,
    localparam int AL_W      = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cfg_sg_en,
    input  logic                 cfg_dir,
    input  logic [ADDR_W-1:0]    cfg_list_base,
    input  logic [PAGE_BITS-1:0] cfg_offset,
    input  logic [LEN_W-1:0]     cfg_len,
    output logic                 lst_req,
    output logic [ADDR_W-1:0]    lst_addr,
    input  logic                 lst_rvalid,
    input  logic [ADDR_W-1:0]    lst_rdata,
    output logic                 beat_valid,
    output logic [ADDR_W-1:0]    beat_addr,
    output logic [BB_W-1:0]      beat_bytes,
    output logic                 beat_dir,
    input  logic                 beat_ready,
    output logic                 done
);
    logic                 load, take_entry, take_beat;
    logic                 page_end, last_beat, list_mode;
    logic [ADDR_W-1:0]    list_ptr;
    logic [FRAME_W-1:0]   frame;
    logic [PAGE_BITS-1:0] offset;
    logic [LEN_W-1:0]     remaining;
    logic [BB_W-1:0]      bytes;
    logic                 dir;

    sg_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .len_zero      (cfg_len == '0),
        .list_mode_req (cfg_sg_en),
        .list_mode_q   (list_mode),
        .lst_rvalid    (lst_rvalid),
        .beat_ready    (beat_ready),
        .last_beat     (last_beat),
        .page_end      (page_end),
        .load          (load),
        .take_entry    (take_entry),
        .take_beat     (take_beat),
        .lst_req       (lst_req),
        .beat_valid    (beat_valid),
        .done          (done)
    );

    sg_cursor #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .PAGE_BITS  (PAGE_BITS),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_cursor (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .take_entry    (take_entry),
        .take_beat     (take_beat),
        .cfg_sg_en     (cfg_sg_en),
        .cfg_dir       (cfg_dir),
        .cfg_list_base (cfg_list_base),
        .cfg_offset    (cfg_offset),
        .cfg_len       (cfg_len),
        .entry_word    (lst_rdata),
        .bytes         (bytes),
        .list_ptr      (list_ptr),
        .frame         (frame),
        .offset        (offset),
        .remaining     (remaining),
        .list_mode     (list_mode),
        .dir           (dir),
        .page_end      (page_end),
        .last_beat     (last_beat)
    );

    sg_beat_calc #(
        .BEAT_BYTES (BEAT_BYTES),
        .LEN_W      (LEN_W)
    ) u_calc (
        .addr_low  (offset[AL_W-1:0]),
        .remaining (remaining),
        .bytes     (bytes)
    );

    always_comb begin
        lst_addr   = list_ptr;
        beat_addr  = {frame, offset};
        beat_bytes = bytes;
        beat_dir   = dir;
    end
endmodule

// File: rtl/sg_addr_gen_chk.sv
module sg_addr_gen_chk #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BITS  = 12,
    parameter int BEAT_BYTES = 4,
    localparam int BB_W      = $clog2(BEAT_BYTES) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lst_req,
    input logic [ADDR_W-1:0] lst_addr,
    input logic              lst_rvalid,
    input logic              beat_valid,
    input logic [ADDR_W-1:0] beat_addr,
    input logic [BB_W-1:0]   beat_bytes,
    input logic              beat_ready,
    input logic              done
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!lst_req && !beat_valid && !done)); // R1

    AST_NO_BEAT_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !lst_req); // R4

    AST_BEAT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_bytes != '0 && beat_bytes <= BB_W'(BEAT_BYTES))); // R5

    AST_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (({1'b0, beat_addr[PAGE_BITS-1:0]} + (PAGE_BITS+1)'(beat_bytes))
                        <= (PAGE_BITS+1)'(1 << PAGE_BITS))); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!lst_req && !beat_valid)); // R7

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_bytes))); // R12

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lst_req && !lst_rvalid) |=> (lst_req && $stable(lst_addr))); // R12
endmodule

bind sg_addr_gen sg_addr_gen_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .BEAT_BYTES (BEAT_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lst_req    (lst_req),
    .lst_addr   (lst_addr),
    .lst_rvalid (lst_rvalid),
    .beat_valid (beat_valid),
    .beat_addr  (beat_addr),
    .beat_bytes (beat_bytes),
    .beat_ready (beat_ready),
    .done       (done)
);

// File: tb/sg_addr_gen_tb.sv
module sg_addr_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int LEN_W = 16;
    localparam int PAGE_BITS = 12;
    localparam int BEAT_BYTES = 4;
    localparam int BB_W = $clog2(BEAT_BYTES) + 1;
    localparam int PAGE = 1 << PAGE_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, cfg_sg_en = 1'b0, cfg_dir = 1'b0;
    logic [ADDR_W-1:0] cfg_list_base = '0;
    logic [PAGE_BITS-1:0] cfg_offset = '0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic lst_req, lst_rvalid = 1'b0;
    logic [ADDR_W-1:0] lst_addr, lst_rdata = '0;
    logic beat_valid, beat_dir, beat_ready = 1'b0, done;
    logic [ADDR_W-1:0] beat_addr;
    logic [BB_W-1:0] beat_bytes;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sg_addr_gen #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS), .BEAT_BYTES(BEAT_BYTES)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_sg_en(cfg_sg_en), .cfg_dir(cfg_dir),
        .cfg_list_base(cfg_list_base), .cfg_offset(cfg_offset), .cfg_len(cfg_len),
        .lst_req(lst_req), .lst_addr(lst_addr), .lst_rvalid(lst_rvalid), .lst_rdata(lst_rdata),
        .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_bytes(beat_bytes),
        .beat_dir(beat_dir), .beat_ready(beat_ready), .done(done)
    );

    function automatic logic [31:0] entry_word(int salt, int k);
        return (32'(salt) * 32'h9E3779B1) ^ (32'(k) * 32'h01000193) ^ 32'h00000ABC;
    endfunction

    function automatic int exp_bytes(int off, int rem);
        int room = BEAT_BYTES - (off % BEAT_BYTES);
        return (rem < room) ? rem : room;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input int salt, input bit sg, input bit dir, input logic [31:0] base,
                       input int offset, input int len, input bit inject);
        int off, page, rem, consumed, fetches, exp_pages, cyc;
        @(negedge clk);
        cfg_sg_en = sg; cfg_dir = dir; cfg_list_base = base;
        cfg_offset = PAGE_BITS'(offset); cfg_len = LEN_W'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (len == 0) begin
            chk(done && !lst_req && !beat_valid, "R10 zero length", {done, lst_req, beat_valid}, 3'b100);
            repeat (3) @(negedge clk);
            chk(done && !lst_req && !beat_valid, "R10 stays quiet", {done, lst_req, beat_valid}, 3'b100);
            return;
        end
        off = sg ? offset : int'(base[PAGE_BITS-1:0]);
        page = 0; rem = len; consumed = 0; fetches = 0;
        exp_pages = sg ? (offset + len + PAGE - 1) / PAGE : 0;
        for (cyc = 0; cyc < 40000; cyc++) begin
            if (rem == 0) begin
                chk(done == 1'b1, "R7 done after last beat", done, 1);
                break;
            end
            if (done) chk(1'b0, "R7 early done", rem, 0);
            lst_rvalid = 1'b0;
            beat_ready = 1'b0;
            if (lst_req) begin
                if (!sg) chk(1'b0, "R8 fetch in flat mode", lst_addr, 0);
                if (beat_valid) chk(1'b0, "R4 beat during fetch", 1, 0);
                if (($urandom % 3) != 0) begin
                    chk(lst_addr == base + 32'(4 * fetches), "R2 table address",
                        lst_addr, base + 32'(4 * fetches));
                    lst_rvalid = 1'b1;
                    lst_rdata = entry_word(salt, fetches);
                    fetches++;
                end
            end
            if (beat_valid && (($urandom % 4) != 0)) begin
                logic [31:0] ea;
                int eb;
                eb = exp_bytes(off, rem);
                if (sg) ea = {entry_word(salt, page)[31:PAGE_BITS], PAGE_BITS'(off)};
                else    ea = base + 32'(consumed);
                chk(beat_addr == ea, sg ? (page == 0 ? "R3 first page address" : "R6 later page address")
                                        : "R8 flat address", beat_addr, ea);
                chk(int'(beat_bytes) == eb, "R5 beat size", beat_bytes, eb);
                chk(beat_dir == dir, "R9 direction", beat_dir, dir);
                beat_ready = 1'b1;
                rem -= eb; consumed += eb; off += eb;
                if (off == PAGE) begin off = 0; page++; end
            end
            if (inject && cyc == 30) begin
                start = 1'b1; cfg_len = 16'd5; cfg_sg_en = !sg; cfg_list_base = 32'hDEAD_0000;
                cfg_dir = !dir;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        lst_rvalid = 1'b0; beat_ready = 1'b0; start = 1'b0;
        chk(rem == 0, "R7 transfer finished", rem, 0);
        if (sg) chk(fetches == exp_pages, "R2 one read per page", fetches, exp_pages);
        if (inject) chk(consumed == len, "R11 start ignored while busy", consumed, len);
        repeat (3) @(negedge clk);
        chk(done && !lst_req && !beat_valid, "R7 quiet after done", {done, lst_req, beat_valid}, 3'b100);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!lst_req && !beat_valid && !done, "R1 reset state", {lst_req, beat_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!lst_req && !beat_valid && !done, "R1 idle after reset", {lst_req, beat_valid, done}, 0);

        run(1, 1'b1, 1'b0, 32'h0010_0000, 4095, 3,    1'b0);  // R6 one byte then crossing
        run(2, 1'b1, 1'b1, 32'h0020_0040, 4094, 2,    1'b0);  // R7 ends on boundary, no extra read
        run(3, 1'b1, 1'b0, 32'h0030_0000, 0,    4096, 1'b0);  // R2 exactly one page
        run(4, 1'b1, 1'b1, 32'h0040_0100, 1,    1,    1'b0);  // R5 single unaligned byte
        run(5, 1'b0, 1'b1, 32'h0005_0FFA, 0,    20,   1'b0);  // R8 flat across page
        run(6, 1'b1, 1'b0, 32'h0060_0000, 10,   0,    1'b0);  // R10 zero length
        run(7, 1'b1, 1'b1, 32'h0070_0200, 4090, 600,  1'b1);  // R11 start mid-transfer
        for (int i = 0; i < 14; i++) begin
            int len = 1 + int'($urandom % 6000);
            int off = int'($urandom % PAGE);
            bit sg = ($urandom % 4) != 0;
            logic [31:0] b = {$urandom} & 32'hFFFF_FFFC;
            if (!sg) b = b + 32'($urandom % 4);
            run(100 + i, sg, 1'($urandom), b, off, len, 1'b0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule